// File: doc/BRIEF.md
# Four-Operator FM Voice Engine

This block produces one signed audio sample per request for a single FM voice. Four sine operators each keep a 20-bit phase accumulator. Each accumulator advances by a base increment times a per-operator multiplier, plus a modulation term taken from the operators earlier in the chain. A 3-bit code selects one of eight fixed routings. The routing decides which operator outputs modulate which operators and which outputs are summed into the voice sample.

A sample request (`sample_strobe`) in the idle state latches the configuration inputs. A small state machine then evaluates the operators one per cycle, in index order, so that every modulator value is ready before its carrier advances. A final mix state registers the sample. A key-on pulse zeroes all four phases and abandons any sample in progress.

States are ST_IDLE, ST_OP0, ST_OP1, ST_OP2, ST_OP3 and ST_MIX. The transitions are:
- ST_IDLE to ST_OP0 on a strobe.
- ST_OP0 to ST_OP1 to ST_OP2 to ST_OP3 to ST_MIX, one per cycle.
- ST_MIX back to ST_IDLE.
- Any state to ST_IDLE on `key_on`, which has priority over everything else.

Top module: `fmx_engine`

## Requirements
- R1: During and after reset, `sample_out` is 0, `sample_valid` is 0 and all four phases are 0.
- R2: A strobe seen at a clock edge in the idle state makes `sample_valid` a one-cycle pulse five edges later, with `sample_out` updated at that edge. Strobes seen while a sample is in progress, or on the mix edge, are ignored.
- R3: The base increment is `freq_num << octave_sel`. Operator i uses its 4-bit multiplier code from bits [4i+3:4i] of `mul_codes`. Code 0 gives half the base increment (shift right by 1); any other code gives base times the code. Phase wraps modulo 2^20.
- R4: Each operator update adds its increment and its sign-extended modulation input shifted left by 4 to the phase. The operator output is then the sine of the new phase.
- R5: The sine uses phase bits [19:10] as index k. Let q be k[7:0], replaced by 255-q when k[8] is 1. Let x = 2q+1. The magnitude is floor(x*(1024-x)/32), and the result is negated when k[9] is 1.
- R6: Codes 0 to 3, output o3. Code 0: o0 modulates op1, o1 modulates op2, o2 modulates op3. Code 1: o0+o1 modulates op2, o2 modulates op3. Code 2: o1 modulates op2, o0+o2 modulates op3. Code 3: o0 modulates op1, o1+o2 modulates op3.
- R7: Code 4: o0 modulates op1, o2 modulates op3, output o1+o3. Code 5: o0 modulates op1, op2 and op3, output o1+o2+o3. Code 6: o0 modulates op1, output o1+o2+o3.
- R8: Code 7 has no modulation, and the output is o0+o1+o2+o3.
- R9: `key_on` at an edge zeroes all phases and returns the machine to idle. It suppresses a pending output pulse and wins over a simultaneous strobe.
- R10: The algorithm code, base increment and multiplier codes are sampled at the accepting edge. Changes during a sample have no effect on that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_on | input | 1 | Phase restart for all operators |
| sample_strobe | input | 1 | Request one sample |
| alg_code | input | 3 | Routing selection |
| freq_num | input | 11 | Frequency number |
| octave_sel | input | 3 | Left shift applied to the frequency number |
| mul_codes | input | 16 | Four 4-bit multiplier codes, operator 0 in the low bits |
| sample_out | output | 16 | Signed voice sample |
| sample_valid | output | 1 | One-cycle pulse marking a new sample |

## Verification
A strobe accepted at edge E0 yields its sample at edge E5: four operator edges and one mix edge follow the accepting edge. A key-on acts at the very next edge. The bench model counts the same five edges from acceptance, and the bench compares `sample_valid` and `sample_out` at every falling edge. Directed checks sample at the falling edge after E5, and they also cover a key-on arriving on any cycle of the window.

// File: rtl/fmx_pkg.sv
package fmx_pkg;
    localparam int NUM_OPS = 4;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_OP0  = 3'd1,
        ST_OP1  = 3'd2,
        ST_OP2  = 3'd3,
        ST_OP3  = 3'd4,
        ST_MIX  = 3'd5
    } fmx_state_e;
endpackage

// File: rtl/fmx_sine.sv
module fmx_sine #(
    parameter int IDX_W = 10,
    parameter int OUT_W = 14
) (
    input  logic [IDX_W-1:0]        idx,
    output logic signed [OUT_W-1:0] wave
);
    localparam int Q_W    = IDX_W - 2;
    localparam int PROD_W = 2 * IDX_W;
    localparam int SHIFT  = 2 * (IDX_W - 1) - (OUT_W - 1);

    logic [Q_W-1:0]    q;
    logic [PROD_W-1:0] x;
    logic [PROD_W-1:0] prod;
    logic [OUT_W-2:0]  mag;
    logic [OUT_W-1:0]  pos;

    // quarter-wave mirror, then a parabolic half-sine
    always_comb begin
        q    = idx[IDX_W-2] ? ~idx[Q_W-1:0] : idx[Q_W-1:0];
        x    = PROD_W'({q, 1'b1});
        prod = x * ((PROD_W'(1) << IDX_W) - x);
        mag  = (OUT_W-1)'(prod >> SHIFT);
        pos  = {1'b0, mag};
        wave = idx[IDX_W-1] ? -pos : pos;
    end
endmodule

// File: rtl/fmx_phase_bank.sv
module fmx_phase_bank
    import fmx_pkg::*;
#(
    parameter int PHASE_W   = 20,
    parameter int MUL_W     = 4,
    parameter int MOD_W     = 16,
    parameter int MOD_SHIFT = 4,
    parameter int OPI_W     = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear,
    input  logic                        adv_en,
    input  logic [OPI_W-1:0]            adv_sel,
    input  logic [PHASE_W-1:0]          base_inc,
    input  logic [NUM_OPS*MUL_W-1:0]    mul_codes,
    input  logic signed [MOD_W-1:0]     mod_in,
    output logic [PHASE_W-1:0]          phase_next,
    output logic [NUM_OPS*PHASE_W-1:0]  phase_flat
);
    localparam int PW = PHASE_W + MUL_W;

    logic [PHASE_W-1:0] ph  [NUM_OPS];
    logic [PHASE_W-1:0] inc [NUM_OPS];
    logic [PHASE_W-1:0] mod_ext;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        logic [MUL_W-1:0] m;
        logic [PW-1:0]    prod;

        assign m      = mul_codes[g*MUL_W +: MUL_W];
        assign prod   = PW'(base_inc) * PW'(m);
        assign inc[g] = (m == '0) ? (base_inc >> 1) : PHASE_W'(prod);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ph[g] <= '0;
            end else if (clear) begin
                ph[g] <= '0;
            end else if (adv_en && adv_sel == OPI_W'(g)) begin
                ph[g] <= phase_next;
            end
        end

        assign phase_flat[g*PHASE_W +: PHASE_W] = ph[g];
    end

    always_comb begin
        mod_ext    = {{(PHASE_W-MOD_W){mod_in[MOD_W-1]}}, mod_in} << MOD_SHIFT;
        phase_next = ph[adv_sel] + inc[adv_sel] + mod_ext;
    end
endmodule

// File: rtl/fmx_route.sv
module fmx_route
    import fmx_pkg::*;
#(
    parameter int OUT_W = 14,
    parameter int MOD_W = 16,
    parameter int OPI_W = 2
) (
    input  logic [2:0]               alg,
    input  logic [OPI_W-1:0]         sel,
    input  logic [NUM_OPS*OUT_W-1:0] outs_flat,
    output logic signed [MOD_W-1:0]  mod_val,
    output logic signed [MOD_W-1:0]  mix
);
    logic signed [MOD_W-1:0] o [NUM_OPS];
    logic signed [MOD_W-1:0] m1, m2, m3;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_ext
        assign o[g] = {{(MOD_W-OUT_W){outs_flat[g*OUT_W+OUT_W-1]}},
                       outs_flat[g*OUT_W +: OUT_W]};
    end

    always_comb begin
        m1  = '0;
        m2  = '0;
        m3  = '0;
        mix = '0;
        unique case (alg)
            3'd0: begin m1 = o[0]; m2 = o[1]; m3 = o[2]; mix = o[3]; end
            3'd1: begin m2 = o[0] + o[1]; m3 = o[2]; mix = o[3]; end
            3'd2: begin m2 = o[1]; m3 = o[0] + o[2]; mix = o[3]; end
            3'd3: begin m1 = o[0]; m3 = o[1] + o[2]; mix = o[3]; end
            3'd4: begin m1 = o[0]; m3 = o[2]; mix = o[1] + o[3]; end
            3'd5: begin m1 = o[0]; m2 = o[0]; m3 = o[0]; mix = o[1] + o[2] + o[3]; end
            3'd6: begin m1 = o[0]; mix = o[1] + o[2] + o[3]; end
            3'd7: begin mix = o[0] + o[1] + o[2] + o[3]; end
            default: ;
        endcase
    end

    always_comb begin
        unique case (sel)
            OPI_W'(1): mod_val = m1;
            OPI_W'(2): mod_val = m2;
            OPI_W'(3): mod_val = m3;
            default:   mod_val = '0;
        endcase
    end
endmodule

// File: rtl/fmx_engine.sv
module fmx_engine
    import fmx_pkg::*;
#(
    parameter int FNUM_W    = 11,
    parameter int OCT_W     = 3,
    parameter int MUL_W     = 4,
    parameter int PHASE_W   = 20,
    parameter int IDX_W     = 10,
    parameter int OUT_W     = 14,
    parameter int MOD_SHIFT = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       key_on,
    input  logic                       sample_strobe,
    input  logic [2:0]                 alg_code,
    input  logic [FNUM_W-1:0]          freq_num,
    input  logic [OCT_W-1:0]           octave_sel,
    input  logic [NUM_OPS*MUL_W-1:0]   mul_codes,
    output logic signed [OUT_W+1:0]    sample_out,
    output logic                       sample_valid
);
    localparam int MOD_W = OUT_W + 2;
    localparam int OPI_W = $clog2(NUM_OPS);

    fmx_state_e state, state_nx;

    logic [2:0]                 cfg_alg;
    logic [PHASE_W-1:0]         cfg_base;
    logic [NUM_OPS*MUL_W-1:0]   cfg_mul;
    logic [NUM_OPS*OUT_W-1:0]   op_out_flat;
    logic [PHASE_W-1:0]         base_now;
    logic [OPI_W-1:0]           cur_op;
    logic                       op_active;
    logic signed [MOD_W-1:0]    mod_val;
    logic signed [MOD_W-1:0]    mix;
    logic [PHASE_W-1:0]         phase_next;
    logic [NUM_OPS*PHASE_W-1:0] phase_flat;
    logic signed [OUT_W-1:0]    wave;

    assign base_now = {{(PHASE_W-FNUM_W){1'b0}}, freq_num} << octave_sel;

    always_comb begin
        cur_op    = '0;
        op_active = 1'b1;
        unique case (state)
            ST_OP0:  cur_op = OPI_W'(0);
            ST_OP1:  cur_op = OPI_W'(1);
            ST_OP2:  cur_op = OPI_W'(2);
            ST_OP3:  cur_op = OPI_W'(3);
            default: op_active = 1'b0;
        endcase
    end

    always_comb begin
        state_nx = state;
        if (key_on) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (sample_strobe) state_nx = ST_OP0;
                ST_OP0:  state_nx = ST_OP1;
                ST_OP1:  state_nx = ST_OP2;
                ST_OP2:  state_nx = ST_OP3;
                ST_OP3:  state_nx = ST_MIX;
                ST_MIX:  state_nx = ST_IDLE;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_alg      <= '0;
            cfg_base     <= '0;
            cfg_mul      <= '0;
            op_out_flat  <= '0;
            sample_out   <= '0;
            sample_valid <= 1'b0;
        end else begin
            sample_valid <= 1'b0;
            if (!key_on) begin
                if (state == ST_IDLE && sample_strobe) begin
                    cfg_alg  <= alg_code;
                    cfg_base <= base_now;
                    cfg_mul  <= mul_codes;
                end
                if (op_active) begin
                    op_out_flat[cur_op*OUT_W +: OUT_W] <= wave;
                end
                if (state == ST_MIX) begin
                    sample_out   <= mix;
                    sample_valid <= 1'b1;
                end
            end
        end
    end

    fmx_phase_bank #(
        .PHASE_W(PHASE_W), .MUL_W(MUL_W), .MOD_W(MOD_W),
        .MOD_SHIFT(MOD_SHIFT), .OPI_W(OPI_W)
    ) u_phase (
        .clk(clk), .rst_n(rst_n), .clear(key_on),
        .adv_en(op_active && !key_on), .adv_sel(cur_op),
        .base_inc(cfg_base), .mul_codes(cfg_mul), .mod_in(mod_val),
        .phase_next(phase_next), .phase_flat(phase_flat)
    );

    fmx_sine #(.IDX_W(IDX_W), .OUT_W(OUT_W)) u_sine (
        .idx(phase_next[PHASE_W-1 -: IDX_W]),
        .wave(wave)
    );

    fmx_route #(.OUT_W(OUT_W), .MOD_W(MOD_W), .OPI_W(OPI_W)) u_route (
        .alg(cfg_alg), .sel(cur_op), .outs_flat(op_out_flat),
        .mod_val(mod_val), .mix(mix)
    );
endmodule

// File: rtl/fmx_engine_chk.sv
module fmx_engine_chk
    import fmx_pkg::*;
#(
    parameter int PHASE_W = 20,
    parameter int OUT_W   = 14
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       key_on,
    input logic                       sample_strobe,
    input fmx_state_e                 state,
    input logic                       sample_valid,
    input logic signed [OUT_W+1:0]    sample_out,
    input logic [4*PHASE_W-1:0]       phase_flat
);
    localparam int PEAK = 4 * ((1 << (OUT_W - 1)) - 1);

    a_r2_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    a_r2_valid_from_mix: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> $past(state) == ST_MIX);

    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && sample_strobe && !key_on) |=> state == ST_OP0);

    a_r2_order: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OP1 && !key_on) |=> state == ST_OP2);

    a_r9_keyon_clear: assert property (@(posedge clk) disable iff (!rst_n)
        key_on |=> (phase_flat == '0 && !sample_valid && state == ST_IDLE));

    a_r5_range: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> (int'(sample_out) <= PEAK && int'(sample_out) >= -PEAK));
endmodule

bind fmx_engine fmx_engine_chk #(.PHASE_W(PHASE_W), .OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .key_on(key_on), .sample_strobe(sample_strobe),
    .state(state), .sample_valid(sample_valid), .sample_out(sample_out),
    .phase_flat(phase_flat)
);

// File: tb/fmx_engine_test.sv
module fmx_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        key_on = 1'b0;
    logic        sample_strobe = 1'b0;
    logic [2:0]  alg_code = '0;
    logic [10:0] freq_num = '0;
    logic [2:0]  octave_sel = '0;
    logic [15:0] mul_codes = '0;
    logic signed [15:0] sample_out;
    logic        sample_valid;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R2";
    bit model_on = 1'b0;

    always #2 clk = ~clk;

    fmx_engine uut (
        .clk(clk), .rst_n(rst_n), .key_on(key_on), .sample_strobe(sample_strobe),
        .alg_code(alg_code), .freq_num(freq_num), .octave_sel(octave_sel),
        .mul_codes(mul_codes), .sample_out(sample_out), .sample_valid(sample_valid)
    );

    // behavioural reference state
    int m_ph[4];
    int m_busy = 0;
    int m_pending = 0;
    int m_sample = 0;
    bit m_valid = 0;
    int m_alg = 0;

    // R5: parabolic sine on a 10-bit index
    function automatic int ref_sine(int k);
        int q = k & 255;
        int x;
        if (k & 256) q = 255 - q;
        x = 2 * q + 1;
        return (k & 512) ? -((x * (1024 - x)) / 32) : ((x * (1024 - x)) / 32);
    endfunction

    function automatic int ref_sample(int alg, int fn, int oc, logic [15:0] mc);
        int o[4];
        int md;
        int base = fn << oc;            // R3
        for (int i = 0; i < 4; i++) begin
            int c = int'(mc[i*4 +: 4]);
            int inc = (c == 0) ? (base >> 1) : base * c;
            md = 0;
            // R6 / R7 / R8 routing of modulators
            case (alg)
                0: md = (i == 1) ? o[0] : (i == 2) ? o[1] : (i == 3) ? o[2] : 0;
                1: md = (i == 2) ? o[0] + o[1] : (i == 3) ? o[2] : 0;
                2: md = (i == 2) ? o[1] : (i == 3) ? o[0] + o[2] : 0;
                3: md = (i == 1) ? o[0] : (i == 3) ? o[1] + o[2] : 0;
                4: md = (i == 1) ? o[0] : (i == 3) ? o[2] : 0;
                5: md = (i >= 1) ? o[0] : 0;
                6: md = (i == 1) ? o[0] : 0;
                default: md = 0;
            endcase
            // R4: modulation shifted by 4, 20-bit wrap
            m_ph[i] = (m_ph[i] + inc + md * 16) & 32'hFFFFF;
            o[i] = ref_sine((m_ph[i] >> 10) & 1023);
        end
        case (alg)
            4:       return o[1] + o[3];
            5, 6:    return o[1] + o[2] + o[3];
            7:       return o[0] + o[1] + o[2] + o[3];
            default: return o[3];
        endcase
    endfunction

    function automatic string alg_tag(int a);
        return (a <= 3) ? "R6" : (a <= 6) ? "R7" : "R8";
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_ph[i] = 0;
            m_busy = 0; m_valid = 0; m_sample = 0;
        end else begin
            m_valid = 0;
            if (key_on) begin                           // R9
                for (int i = 0; i < 4; i++) m_ph[i] = 0;
                m_busy = 0;
            end else if (m_busy == 5) begin             // R2
                m_valid = 1; m_sample = m_pending; m_busy = 0;
            end else if (m_busy > 0) begin
                m_busy++;
            end else if (sample_strobe) begin           // R10: sampled here only
                m_alg = int'(alg_code);
                m_pending = ref_sample(int'(alg_code), int'(freq_num), int'(octave_sel), mul_codes);
                m_busy = 1;
            end
        end
    end

    task automatic check_int(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && model_on) begin
            check_int({cur_tag, " valid"}, int'(sample_valid), int'(m_valid));
            if (m_valid)
                check_int({alg_tag(m_alg), "(R3,R4,R5) ", cur_tag, " sample"},
                          int'(sample_out), m_sample);
        end
    end

    task automatic strobe(int a, int fn, int oc, logic [15:0] mc);
        alg_code = 3'(a); freq_num = 11'(fn); octave_sel = 3'(oc); mul_codes = mc;
        sample_strobe = 1'b1;
        @(negedge clk);
        sample_strobe = 1'b0;
    endtask

    initial begin
        logic [15:0] mset[3];
        int fset[3];
        int oset[3];
        mset[0] = 16'h4321; mset[1] = 16'hF0A1; mset[2] = 16'h0000;
        fset[0] = 'h2A5;    fset[1] = 'h7FF;    fset[2] = 'h155;
        oset[0] = 4;        oset[1] = 7;        oset[2] = 1;

        repeat (4) @(negedge clk);
        check_int("R1 reset valid", int'(sample_valid), 0);
        check_int("R1 reset sample", int'(sample_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        model_on = 1'b1;

        // R1 + R8: zero phases, no increment -> 4 * sine(0) = 124
        cur_tag = "R1";
        strobe(7, 0, 0, 16'h1111);
        repeat (4) @(negedge clk);
        check_int("R2 latency valid", int'(sample_valid), 0);
        @(negedge clk);
        check_int("R2 latency valid", int'(sample_valid), 1);
        check_int("R8 zero-phase sum", int'(sample_out), 124);
        @(negedge clk);
        check_int("R2 single pulse", int'(sample_valid), 0);

        // R6 R7 R8 across settings; R3 multiplier code 0 in mset
        cur_tag = "R3";
        for (int a = 0; a < 8; a++)
            for (int s = 0; s < 3; s++)
                for (int r = 0; r < 3; r++) begin
                    strobe(a, fset[s], oset[s], mset[(s + r) % 3]);
                    repeat (5 + r) @(negedge clk);
                end

        // R2: strobe held high, extra strobes ignored while busy
        cur_tag = "R2";
        alg_code = 3'd5; freq_num = 11'h3C1; octave_sel = 3'd5; mul_codes = 16'h2713;
        sample_strobe = 1'b1;
        repeat (25) @(negedge clk);
        sample_strobe = 1'b0;
        repeat (6) @(negedge clk);

        // R10: inputs change during a sample
        cur_tag = "R10";
        for (int a = 0; a < 8; a++) begin
            strobe(a, 'h1F3, 6, 16'h5A3C);
            alg_code = 3'(7 - a); freq_num = 11'h7FF; octave_sel = 3'd7; mul_codes = 16'hFFFF;
            repeat (6) @(negedge clk);
        end

        // R9: key-on on each cycle of a sample window
        cur_tag = "R9";
        for (int d = 0; d < 6; d++) begin
            strobe(2, 'h2B7, 6, 16'h3521);
            repeat (d) @(negedge clk);
            key_on = 1'b1;
            @(negedge clk);
            key_on = 1'b0;
            repeat (6) @(negedge clk);
        end
        // key-on wins over a simultaneous strobe
        key_on = 1'b1;
        strobe(1, 'h400, 3, 16'h1111);
        key_on = 1'b0;
        repeat (6) @(negedge clk);
        check_int("R9 strobe with key-on dropped", int'(sample_valid), 0);
        // phases restarted: the zero-increment sum is back to 124
        strobe(7, 0, 0, 16'h1111);
        repeat (5) @(negedge clk);
        check_int("R9 phases cleared", int'(sample_out), 124);
        @(negedge clk);

        model_on = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule